// File: doc/BRIEF.md
# Twelve-Hour Time-of-Day Core

This block keeps the time of day in twelve-hour form. Hours run from 1 to 12 and minutes from 0 to 59. Both are held as binary-coded decimal, so the four output digits can go straight to a display driver.

A strobe that arrives once a minute advances the time in normal running. Two held set buttons let a user adjust each field at a rate of one step per second: one button steps the hour and the other steps the minute. A synchronous active-low reset loads 12:00.

Debouncing the buttons, generating the strobes and multiplexing a segment display all belong to neighbouring logic and are not part of this block.

Top module: `tod_clock12`

## Requirements
- R1: While `rst_n` is low at a clock edge, the time becomes 12:00 after that edge (digits 1,2,0,0). This happens whatever the buttons and strobes are doing.
- R2: With neither button held, each cycle with `min_tick` high advances the minute by one. A `sec_tick` alone changes nothing. When both strobes are high together, the time advances by exactly one minute.
- R3: In normal running, a minute advance from 59 gives 00 and carries one hour: 11:59 becomes 12:00, and 12:59 becomes 01:00.
- R4: The hour steps 12, 1, 2, ... 11, 12. There is never a zero hour, and twelve hour steps return to the starting value.
- R5: While `hour_btn` is held, each `sec_tick` advances the hour by one and leaves the minutes unchanged.
- R6: While `min_btn` is held, each `sec_tick` advances the minute by one. The wrap from 59 to 00 leaves the hour unchanged.
- R7: While either button is held, `min_tick` has no effect.
- R8: Each output digit is a 4-bit binary value from 0 to 9:
  - `hr_tens` is 0 or 1;
  - `mn_tens` is from 0 to 5;
  - `hr_tens`:`hr_ones` lies from 01 to 12.
- R9: With both buttons held, each `sec_tick` advances the hour and the minute by one each, and the minute wrap adds no carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads 12:00 |
| min_tick | input | 1 | One-cycle strobe, once per minute |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| hour_btn | input | 1 | Hour set button, high while held |
| min_btn | input | 1 | Minute set button, high while held |
| hr_tens | output | 4 | Hour tens digit (0 or 1) |
| hr_ones | output | 4 | Hour ones digit |
| mn_tens | output | 4 | Minute tens digit (0 to 5) |
| mn_ones | output | 4 | Minute ones digit |

## Verification
The assertions check the following on every cycle:
- both fields stay in their legal ranges;
- reset leads to 12:00;
- the time stays frozen while a button is held and no seconds strobe arrives;
- the hour moves only on an hour-button step or on a normal carry out of :59;
- the hour-set and minute-set paths each leave the other field alone.

Only the bench scenarios can show the following: the exact step order through 12 → 1 and 09 → 10, the carries at 11:59 and 12:59, the arbitration of coincident strobes and buttons, and a full twelve hours of minute strobes matched against an independent model.

// File: rtl/tod_pkg.sv
// Shared digit type and range limits for the twelve-hour time-of-day core.
package tod_pkg;
    localparam int DIGIT_W = 4;
    typedef logic [DIGIT_W-1:0] digit_t;

    localparam digit_t ONES_LAST      = digit_t'(9);
    localparam digit_t MIN_TENS_LAST  = digit_t'(5);
    localparam digit_t HR_TOP_TENS    = digit_t'(1);
    localparam digit_t HR_TOP_ONES    = digit_t'(2);
    localparam digit_t HR_FIRST_ONES  = digit_t'(1);
    localparam digit_t ZERO_DIGIT     = digit_t'(0);
endpackage

// File: rtl/tod_bcd_digit.sv
// One decimal digit that counts 0..LAST and wraps to zero.
// Assumes: inc is a single-cycle step request; LAST is at most 9.
// wrap is combinational and signals that this step rolls the digit over.
module tod_bcd_digit
    import tod_pkg::*;
#(
    parameter digit_t LAST = ONES_LAST
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   inc,
    output digit_t q,
    output logic   wrap
);
    // Roll-over indication for the next digit up.
    assign wrap = inc && (q == LAST);

    // Digit register: clear on reset, step or wrap on inc.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= ZERO_DIGIT;
        else if (inc)
            q <= wrap ? ZERO_DIGIT : q + digit_t'(1);
    end
endmodule

// File: rtl/tod_minute.sv
// Modulo-60 minute counter built from two decimal digits.
// Assumes: inc is at most one step per cycle. carry is high on the step from 59.
module tod_minute
    import tod_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   inc,
    output digit_t tens,
    output digit_t ones,
    output logic   carry
);
    localparam int NDIG = 2;

    digit_t dig_q    [NDIG];
    logic   dig_inc  [NDIG];
    logic   dig_wrap [NDIG];

    // Ripple the step from the ones digit into the tens digit.
    genvar g;
    generate
        for (g = 0; g < NDIG; g++) begin : g_dig
            localparam digit_t LIM = (g == 0) ? ONES_LAST : MIN_TENS_LAST;
            if (g == 0) begin : g_first
                assign dig_inc[g] = inc;
            end else begin : g_rest
                assign dig_inc[g] = dig_wrap[g-1];
            end
            tod_bcd_digit #(.LAST(LIM)) u_digit (
                .clk  (clk),
                .rst_n(rst_n),
                .inc  (dig_inc[g]),
                .q    (dig_q[g]),
                .wrap (dig_wrap[g])
            );
        end
    endgenerate

    assign ones  = dig_q[0];
    assign tens  = dig_q[NDIG-1];
    assign carry = dig_wrap[NDIG-1];
endmodule

// File: rtl/tod_hour.sv
// Twelve-hour counter in BCD: 12, 01, 02 .. 09, 10, 11, 12.
// Assumes: inc is at most one step per cycle; reset value is 12.
module tod_hour
    import tod_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   inc,
    output digit_t tens,
    output digit_t ones
);
    digit_t nxt_tens, nxt_ones;
    logic   at_top, at_nine;

    // Next-hour decode: 12 goes to 01, 09 goes to 10, otherwise ones+1.
    always_comb begin
        at_top   = (tens == HR_TOP_TENS) && (ones == HR_TOP_ONES);
        at_nine  = (tens == ZERO_DIGIT) && (ones == ONES_LAST);
        nxt_tens = tens;
        nxt_ones = ones + digit_t'(1);
        if (at_top) begin
            nxt_tens = ZERO_DIGIT;
            nxt_ones = HR_FIRST_ONES;
        end else if (at_nine) begin
            nxt_tens = HR_TOP_TENS;
            nxt_ones = ZERO_DIGIT;
        end
    end

    // Hour registers: reset to 12, step on inc.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tens <= HR_TOP_TENS;
            ones <= HR_TOP_ONES;
        end else if (inc) begin
            tens <= nxt_tens;
            ones <= nxt_ones;
        end
    end
endmodule

// File: rtl/tod_ctrl.sv
// Step arbitration: set buttons override the minute strobe.
// Minute carry into the hour is allowed only in normal running.
module tod_ctrl (
    input  logic min_tick,
    input  logic sec_tick,
    input  logic hour_btn,
    input  logic min_btn,
    input  logic min_carry,
    output logic min_inc,
    output logic hr_inc
);
    logic setting;

    // Decide which fields step this cycle.
    always_comb begin
        setting = hour_btn || min_btn;
        min_inc = setting ? (min_btn && sec_tick) : min_tick;
        hr_inc  = (hour_btn && sec_tick) || (!setting && min_carry);
    end
endmodule

// File: rtl/tod_clock12.sv
// Top of the twelve-hour time-of-day core.
// Assumes: strobes are one cycle wide and buttons are already debounced.
module tod_clock12
    import tod_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               min_tick,
    input  logic               sec_tick,
    input  logic               hour_btn,
    input  logic               min_btn,
    output logic [DIGIT_W-1:0] hr_tens,
    output logic [DIGIT_W-1:0] hr_ones,
    output logic [DIGIT_W-1:0] mn_tens,
    output logic [DIGIT_W-1:0] mn_ones
);
    logic min_inc, hr_inc, min_carry;

    tod_ctrl u_ctrl (
        .min_tick (min_tick),
        .sec_tick (sec_tick),
        .hour_btn (hour_btn),
        .min_btn  (min_btn),
        .min_carry(min_carry),
        .min_inc  (min_inc),
        .hr_inc   (hr_inc)
    );

    tod_minute u_min (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (min_inc),
        .tens (mn_tens),
        .ones (mn_ones),
        .carry(min_carry)
    );

    tod_hour u_hr (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (hr_inc),
        .tens (hr_tens),
        .ones (hr_ones)
    );
endmodule

// File: rtl/tod_clock12_chk.sv
// Cycle checks for tod_clock12, bound to every instance of the top.
module tod_clock12_chk
    import tod_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   min_tick,
    input logic   sec_tick,
    input logic   hour_btn,
    input logic   min_btn,
    input digit_t hr_tens,
    input digit_t hr_ones,
    input digit_t mn_tens,
    input digit_t mn_ones
);
    // R1
    reset_noon_chk: assert property (@(posedge clk)
        !rst_n |=> (hr_tens == 4'd1 && hr_ones == 4'd2 && mn_tens == 4'd0 && mn_ones == 4'd0));

    // R8
    hour_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hr_tens == 4'd0 && hr_ones >= 4'd1 && hr_ones <= 4'd9) ||
        (hr_tens == 4'd1 && hr_ones <= 4'd2));

    // R8
    minute_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mn_tens <= 4'd5 && mn_ones <= 4'd9);

    // R7
    set_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((hour_btn || min_btn) && !sec_tick) |=>
        ($stable(hr_tens) && $stable(hr_ones) && $stable(mn_tens) && $stable(mn_ones)));

    // R6
    min_set_keeps_hour_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (min_btn && !hour_btn) |=> ($stable(hr_tens) && $stable(hr_ones)));

    // R5
    hour_set_keeps_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hour_btn && !min_btn) |=> ($stable(mn_tens) && $stable(mn_ones)));

    // R3
    hour_moves_only_on_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hour_btn && !(min_tick && !min_btn && mn_tens == 4'd5 && mn_ones == 4'd9)) |=>
        ($stable(hr_tens) && $stable(hr_ones)));
endmodule

bind tod_clock12 tod_clock12_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .min_tick(min_tick),
    .sec_tick(sec_tick),
    .hour_btn(hour_btn),
    .min_btn (min_btn),
    .hr_tens (hr_tens),
    .hr_ones (hr_ones),
    .mn_tens (mn_tens),
    .mn_ones (mn_ones)
);

// File: tb/tb_tod_clock12.sv
module tb_tod_clock12;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       min_tick = 1'b0, sec_tick = 1'b0, hour_btn = 1'b0, min_btn = 1'b0;
    logic [3:0] hr_tens, hr_ones, mn_tens, mn_ones;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;
    int         mh = 12, mm = 0;

    always #5 clk = ~clk;

    tod_clock12 dut (
        .clk(clk), .rst_n(rst_n), .min_tick(min_tick), .sec_tick(sec_tick),
        .hour_btn(hour_btn), .min_btn(min_btn),
        .hr_tens(hr_tens), .hr_ones(hr_ones), .mn_tens(mn_tens), .mn_ones(mn_ones)
    );

    // Vector: {req[3:0], rst_n, hour_btn, min_btn, min_tick, sec_tick, expected hh:mm BCD[15:0]}
    localparam int NV = 10;
    localparam logic [24:0] VEC [NV] = '{
        {4'd2, 5'b10010, 16'h1201},   // R2 minute strobe
        {4'd2, 5'b10001, 16'h1201},   // R2 second strobe alone ignored
        {4'd5, 5'b11001, 16'h0101},   // R5 hour set 12 -> 01
        {4'd7, 5'b11010, 16'h0101},   // R7 minute strobe ignored while hour held
        {4'd6, 5'b10101, 16'h0102},   // R6 minute set
        {4'd7, 5'b10110, 16'h0102},   // R7 minute strobe ignored while minute held
        {4'd9, 5'b11101, 16'h0203},   // R9 both buttons
        {4'd2, 5'b10011, 16'h0204},   // R2 both strobes: one minute
        {4'd1, 5'b01011, 16'h1200},   // R1 reset wins over everything
        {4'd2, 5'b10010, 16'h1201}    // R2 runs after reset
    };

    function automatic logic [15:0] bcd(input int h, input int m);
        return {4'(h / 10), 4'(h % 10), 4'(m / 10), 4'(m % 10)};
    endfunction

    function automatic logic [15:0] now_q();
        return {hr_tens, hr_ones, mn_tens, mn_ones};
    endfunction

    // Drive one cycle from a negedge and return at the following negedge.
    task automatic cyc(input logic r, input logic hb, input logic mb, input logic mt, input logic st);
        rst_n = r; hour_btn = hb; min_btn = mb; min_tick = mt; sec_tick = st;
        @(negedge clk);
        rst_n = 1'b1; hour_btn = 1'b0; min_btn = 1'b0; min_tick = 1'b0; sec_tick = 1'b0;
    endtask

    task automatic check(input string req, input logic [15:0] exp);
        n_chk++;
        if (now_q() !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, now_q(), exp);
        end
    endtask

    function automatic int hr_next(input int h);
        return (h == 12) ? 1 : h + 1;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R1", 16'h1200);                       // R1 reset state

        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i][20], VEC[i][19], VEC[i][18], VEC[i][17], VEC[i][16]);
            n_chk++;
            if (now_q() !== VEC[i][15:0]) begin
                n_bad++;
                $display("FAIL R%0d vec %0d actual=%h expected=%h", VEC[i][24:21], i, now_q(), VEC[i][15:0]);
            end
        end

        // R4: twelve hour-set steps from 12 visit 1..11 and return to 12
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        mh = 12; mm = 0;
        for (int i = 0; i < 12; i++) begin
            cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
            mh = hr_next(mh);
            check("R4", bcd(mh, mm));
        end

        // R3: set 11:59, then one minute strobe gives 12:00
        for (int i = 0; i < 11; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 59; i++) cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        check("R6", 16'h1159);
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        check("R3", 16'h1200);

        // R3: 12:59 -> 01:00
        for (int i = 0; i < 59; i++) cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        check("R6", 16'h1259);
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        check("R3", 16'h0100);

        // R6: minute-set wrap 59 -> 00 keeps the hour
        for (int i = 0; i < 59; i++) cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        check("R6", 16'h0159);
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        check("R6", 16'h0100);

        // R9: both buttons at 01:59 -> 02:00 with no carry into the hour
        for (int i = 0; i < 59; i++) cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        check("R9", 16'h0200);

        // R2 R3 R4 R8: twelve hours of minute strobes against a model
        mh = 2; mm = 0;
        for (int i = 0; i < 720; i++) begin
            cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
            mm++;
            if (mm == 60) begin mm = 0; mh = hr_next(mh); end
            check("R2/R3/R8", bcd(mh, mm));
        end
        check("R4", 16'h0200);

        // R1: reset during a held hour button mid-run
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
        check("R1", 16'h1200);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule